// File: doc/BRIEF.md
# Dual-Carrier Sine-Triangle Gate Generator with Shoot-Through Insertion

This block produces the six gate signals of a three-phase impedance-source inverter bridge. Three signed modulating words are compared against a symmetric triangular AC carrier. The result gives the high-side gate of each leg, and the low-side gate is its complement. A second triangle, folded from the same counter, runs at twice the AC rate and is compared with a DC-link shoot-through command. When that comparison requests shoot-through and all three legs sit in a zero-voltage state, both switches of every leg are driven on. A charge-mode flag suppresses shoot-through and turns on the enable of the bidirectional input transistor.

The carrier is an up/down counter controlled by a small state machine with three states. ARM is entered on reset: the counter rises while all gates are held low. RISE counts up and FALL counts down. The transitions are ARM to FALL at the first peak, RISE to FALL at every later peak, and FALL to RISE at every trough. The modulating words, the clamped shoot-through command and the period are captured only at a peak, so an update written mid-period can never produce a partial pulse.

Top module: `st_spwm_gen`

## Requirements
- R1: The AC carrier value c follows the sequence 0,1,…,P,P-1,…,1,0,1,…. Its period is 2P cycles, where P is the period input (values below 2 act as 2). Leg x's high gate is 1 when its signed modulating word is greater than 2c-P.
- R2: Outside shoot-through, each leg's low-side gate equals the inverse of its high-side gate. Gate vector bit 0 is leg a, bit 1 is leg b and bit 2 is leg c.
- R3: The shoot-through carrier is s=|2c-P|. It completes two triangles per AC period and stays phase-locked to the AC carrier. Shoot-through is requested when s+T>P, where T is the threshold defined in R5.
- R4: Shoot-through (all six gates at 1) is applied only when the three high-side comparisons are all 0 or all 1.
- R5: The command is an unsigned fraction with 15 fractional bits, so 32768 means 1.0. The threshold is T=floor(cmd·P/32768), which makes the command equal to the shoot-through duty.
- R6: Before use, the command is clamped to the maximum-duty input, which uses the same format.
- R7: When the charge flag is 1, no shoot-through is produced and the input-transistor enable is 1. When the flag is 0, the enable is 0.
- R8: The modulating words, the command, the maximum and the period take effect only at a carrier peak. Changes made at other times have no effect until the next peak.
- R9: During reset, and from reset release through the first peak (cycle P after release), all gates are 0.
- R10: Each output is registered and reflects the carrier value of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period | input | CW | AC carrier half-period P in cycles |
| mod_a | input | CW+1 | Signed modulating word, leg a |
| mod_b | input | CW+1 | Signed modulating word, leg b |
| mod_c | input | CW+1 | Signed modulating word, leg c |
| st_cmd | input | CW | Shoot-through duty command, 15 fractional bits |
| st_max | input | CW | Shoot-through duty ceiling, same format |
| charge_mode | input | 1 | 1 selects grid-to-battery charging |
| gate_hi | output | 3 | High-side gates, legs c..a |
| gate_lo | output | 3 | Low-side gates, legs c..a |
| inp_sw_en | output | 1 | Enable for the bidirectional input transistor |

## Verification
Counting clock edges from reset release, the edge with index n sees carrier value c(n), which the bench folds from n mod 2P. The gate and enable outputs change one edge later, so every check samples at the falling edge that follows edge n and compares against values predicted from c(n). New words become visible starting with the edge after a peak at index P+2Pk. The bench therefore captures its own copy of the words at those indices, after it has computed that edge's expectation. For every edge up to and including index P, the bench expects all gates to be low.

// File: rtl/st_spwm_pkg.sv
package st_spwm_pkg;
    typedef enum logic [1:0] {
        CAR_ARM  = 2'd0,
        CAR_RISE = 2'd1,
        CAR_FALL = 2'd2
    } car_state_e;
endpackage

// File: rtl/st_carrier.sv
module st_carrier
    import st_spwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] per_q,
    output car_state_e    state,
    output logic          peak
);
    localparam logic [CW-1:0] ONE     = CW'(1);
    localparam logic [CW-1:0] MIN_PER = CW'(2);

    car_state_e    nxt;
    logic [CW-1:0] per_safe;

    assign per_safe = (period < MIN_PER) ? MIN_PER : period;
    assign peak     = (state != CAR_FALL) && (cnt == per_q);

    always_ff @(posedge clk) begin
        if (rst) state <= CAR_ARM;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CAR_ARM, CAR_RISE: if (peak) nxt = CAR_FALL;
            CAR_FALL:          if (cnt == '0) nxt = CAR_RISE;
            default:           nxt = CAR_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            per_q <= per_safe;
        end else begin
            if (peak) per_q <= per_safe;
            unique case (state)
                CAR_ARM, CAR_RISE: cnt <= peak ? cnt - ONE : cnt + ONE;
                CAR_FALL:          cnt <= (cnt == '0) ? ONE : cnt - ONE;
                default:           cnt <= '0;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state != CAR_FALL) |-> (cnt <= per_q)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE))); // R1
endmodule

// File: rtl/st_word_latch.sv
module st_word_latch #(
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 peak,
    input  logic signed [CW:0]   mod_a,
    input  logic signed [CW:0]   mod_b,
    input  logic signed [CW:0]   mod_c,
    input  logic [CW-1:0]        st_cmd,
    input  logic [CW-1:0]        st_max,
    output logic signed [CW:0]   ma_q,
    output logic signed [CW:0]   mb_q,
    output logic signed [CW:0]   mc_q,
    output logic [CW-1:0]        cmd_q
);
    logic [CW-1:0] cmd_lim;

    assign cmd_lim = (st_cmd > st_max) ? st_max : st_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ma_q  <= '0;
            mb_q  <= '0;
            mc_q  <= '0;
            cmd_q <= '0;
        end else if (peak) begin
            ma_q  <= mod_a;
            mb_q  <= mod_b;
            mc_q  <= mod_c;
            cmd_q <= cmd_lim;
        end
    end

    AST_HOLD_OFF_PEAK: assert property (@(posedge clk) disable iff (rst)
        !peak |=> $stable({ma_q, mb_q, mc_q, cmd_q})); // R8
endmodule

// File: rtl/st_gate_drv.sv
module st_gate_drv
    import st_spwm_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FRAC = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  car_state_e         state,
    input  logic [CW-1:0]      cnt,
    input  logic [CW-1:0]      per_q,
    input  logic signed [CW:0] ma_q,
    input  logic signed [CW:0] mb_q,
    input  logic signed [CW:0] mc_q,
    input  logic [CW-1:0]      cmd_q,
    input  logic               charge,
    output logic [2:0]         gate_hi,
    output logic [2:0]         gate_lo,
    output logic               inp_en
);
    localparam int SW    = CW + 2;
    localparam int PW    = 2 * CW;
    localparam int WW    = PW + 1;
    localparam int LEGS  = 3;

    logic signed [SW-1:0] car;
    logic [SW-1:0]        mag;
    logic signed [SW-1:0] lvl [LEGS];
    logic [LEGS-1:0]      hi_raw;
    logic                 zero_vec;
    logic [PW-1:0]        prod;
    logic [PW-1:0]        thr;
    logic                 st_req;
    logic                 st_on;

    assign car = $signed({1'b0, cnt, 1'b0}) - $signed({2'b00, per_q});
    assign mag = car[SW-1] ? $unsigned(-car) : $unsigned(car);

    assign lvl[0] = $signed({ma_q[CW], ma_q});
    assign lvl[1] = $signed({mb_q[CW], mb_q});
    assign lvl[2] = $signed({mc_q[CW], mc_q});

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        assign hi_raw[g] = lvl[g] > car;
    end

    assign zero_vec = (hi_raw == '0) || (hi_raw == '1);
    assign prod     = {{CW{1'b0}}, cmd_q} * {{CW{1'b0}}, per_q};
    assign thr      = prod >> FRAC;
    assign st_req   = (WW'(mag) + WW'(thr)) > WW'(per_q);
    assign st_on    = st_req && zero_vec && !charge;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_hi <= '0;
            gate_lo <= '0;
            inp_en  <= 1'b0;
        end else begin
            inp_en <= charge;
            unique case (state)
                CAR_ARM: begin
                    gate_hi <= '0;
                    gate_lo <= '0;
                end
                CAR_RISE, CAR_FALL: begin
                    gate_hi <= st_on ? '1 : hi_raw;
                    gate_lo <= st_on ? '1 : ~hi_raw;
                end
                default: begin
                    gate_hi <= '0;
                    gate_lo <= '0;
                end
            endcase
        end
    end

    AST_LO_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        ((gate_hi & gate_lo) == 3'b000 && (gate_hi | gate_lo) != 3'b000)
        |-> (gate_lo == ~gate_hi)); // R2
    AST_ST_ALL_LEGS: assert property (@(posedge clk) disable iff (rst)
        ((gate_hi & gate_lo) != 3'b000)
        |-> (gate_hi == 3'b111 && gate_lo == 3'b111 && !inp_en)); // R4
    AST_CHARGE_EN: assert property (@(posedge clk) disable iff (rst)
        charge |=> inp_en); // R7
    AST_ARM_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == CAR_ARM) |=> (gate_hi == 3'b000 && gate_lo == 3'b000)); // R9
endmodule

// File: rtl/st_spwm_gen.sv
module st_spwm_gen
    import st_spwm_pkg::*;
#(
    parameter int CW   = 16,
    parameter int FRAC = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CW-1:0]      period,
    input  logic signed [CW:0] mod_a,
    input  logic signed [CW:0] mod_b,
    input  logic signed [CW:0] mod_c,
    input  logic [CW-1:0]      st_cmd,
    input  logic [CW-1:0]      st_max,
    input  logic               charge_mode,
    output logic [2:0]         gate_hi,
    output logic [2:0]         gate_lo,
    output logic               inp_sw_en
);
    car_state_e         state;
    logic [CW-1:0]      cnt;
    logic [CW-1:0]      per_q;
    logic               peak;
    logic signed [CW:0] ma_q;
    logic signed [CW:0] mb_q;
    logic signed [CW:0] mc_q;
    logic [CW-1:0]      cmd_q;

    st_carrier #(.CW(CW)) u_car (
        .clk    (clk),
        .rst    (rst),
        .period (period),
        .cnt    (cnt),
        .per_q  (per_q),
        .state  (state),
        .peak   (peak)
    );

    st_word_latch #(.CW(CW)) u_lat (
        .clk    (clk),
        .rst    (rst),
        .peak   (peak),
        .mod_a  (mod_a),
        .mod_b  (mod_b),
        .mod_c  (mod_c),
        .st_cmd (st_cmd),
        .st_max (st_max),
        .ma_q   (ma_q),
        .mb_q   (mb_q),
        .mc_q   (mc_q),
        .cmd_q  (cmd_q)
    );

    st_gate_drv #(.CW(CW), .FRAC(FRAC)) u_drv (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .cnt     (cnt),
        .per_q   (per_q),
        .ma_q    (ma_q),
        .mb_q    (mb_q),
        .mc_q    (mc_q),
        .cmd_q   (cmd_q),
        .charge  (charge_mode),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo),
        .inp_en  (inp_sw_en)
    );
endmodule

// File: tb/tb_st_spwm_gen.sv
module tb_st_spwm_gen;
    localparam int CLK_NS = 10;
    localparam int CW     = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [CW-1:0]      period = 16'd4;
    logic signed [CW:0] mod_a = '0;
    logic signed [CW:0] mod_b = '0;
    logic signed [CW:0] mod_c = '0;
    logic [CW-1:0]      st_cmd = '0;
    logic [CW-1:0]      st_max = '0;
    logic               charge_mode = 1'b0;
    logic [2:0]         gate_hi;
    logic [2:0]         gate_lo;
    logic               inp_sw_en;

    int n_checks = 0;
    int n_fail   = 0;
    int ea, eb, ec, ecmd;

    always #(CLK_NS/2) clk = ~clk;

    st_spwm_gen dut (
        .clk(clk), .rst(rst), .period(period),
        .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
        .st_cmd(st_cmd), .st_max(st_max), .charge_mode(charge_mode),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .inp_sw_en(inp_sw_en)
    );

    // expected {hi[2:0], lo[2:0], en} after edge n, from carrier value at edge n
    function automatic logic [6:0] expect_at(int n, int p, bit chg);
        int m, c, car, s, thr;
        logic [2:0] h;
        m = n % (2 * p);
        c = (m <= p) ? m : 2 * p - m;
        if (n <= p) return {6'b000000, chg};
        car  = 2 * c - p;
        h[0] = ea > car;
        h[1] = eb > car;
        h[2] = ec > car;
        s    = (car < 0) ? -car : car;
        thr  = (ecmd * p) / 32768;
        if (!chg && (h == 3'b000 || h == 3'b111) && (s + thr > p))
            return {6'b111111, chg};
        return {h, ~h, chg};
    endfunction

    task automatic check(input logic [6:0] exp, input string tag, input int n);
        logic [6:0] act;
        act = {gate_hi, gate_lo, inp_sw_en};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual hi/lo/en=%b expected %b", tag, n, act, exp);
        end
    endtask

    task automatic run(input int p_raw, input int a, input int b, input int c,
                       input int cmd, input int mx, input bit chg, input int ncyc,
                       input string tag, input int mid_n, input int mid_a);
        int p;
        logic [6:0] exp;
        p = (p_raw < 2) ? 2 : p_raw;
        period = CW'(p_raw);
        mod_a = (CW+1)'(a); mod_b = (CW+1)'(b); mod_c = (CW+1)'(c);
        st_cmd = CW'(cmd); st_max = CW'(mx); charge_mode = chg;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(7'b0000000, "R9", -1); // reset state
        rst = 1'b0;
        for (int n = 0; n < ncyc; n++) begin
            @(posedge clk);
            exp = expect_at(n, p, chg);
            if (n >= p && ((n - p) % (2 * p)) == 0) begin
                ea = int'(mod_a); eb = int'(mod_b); ec = int'(mod_c);
                ecmd = (int'(st_cmd) > int'(st_max)) ? int'(st_max) : int'(st_cmd);
            end
            @(negedge clk);
            check(exp, (n <= p) ? "R9" : tag, n);
            if (n == mid_n) mod_a = (CW+1)'(mid_a);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: modulating sweeps across several periods, no shoot-through
        for (int p = 4; p <= 8; p += 2)
            for (int a = -p; a <= p; a += 2)
                run(p, a, -a, a / 2, 0, 32768, 1'b0, 5 * p + 2, "R1", -1, 0);
        run(1, 1, -1, 0, 0, 32768, 1'b0, 14, "R1", -1, 0); // period clamp to 2
        // R2: complementary low side
        run(6, 2, -3, 0, 0, 32768, 1'b0, 40, "R2", -1, 0);
        // R3: doubled-rate carrier, common mode words
        for (int k = 1; k <= 4; k++)
            run(8, 0, 0, 0, 8192 * k, 32768, 1'b0, 45, "R3", -1, 0);
        // R4: differing words, shoot-through only in zero states
        run(8, 4, -4, 0, 32768, 32768, 1'b0, 45, "R4", -1, 0);
        run(6, 6, 6, -6, 24576, 32768, 1'b0, 40, "R4", -1, 0);
        // R5: duty scaling sweep
        for (int k = 0; k <= 8; k++)
            run(6, 6, 6, 6, 4096 * k, 32768, 1'b0, 32, "R5", -1, 0);
        // R6: clamp to maximum duty
        run(8, 0, 0, 0, 32768, 4096, 1'b0, 45, "R6", -1, 0);
        run(8, 0, 0, 0, 60000, 16384, 1'b0, 45, "R6", -1, 0);
        // R7: charge mode kills shoot-through and raises the enable
        run(8, 0, 0, 0, 32768, 32768, 1'b1, 45, "R7", -1, 0);
        run(6, 3, -2, 1, 16384, 32768, 1'b1, 40, "R7", -1, 0);
        // R8: mid-period change waits for the next peak
        run(8, -8, 0, 0, 0, 32768, 1'b0, 60, "R8", 11, 8);
        run(6, 5, -5, 0, 0, 32768, 1'b0, 50, "R8", 21, -5);
        // R10: odd period, one-cycle registered outputs
        run(5, 1, -2, 3, 12000, 32768, 1'b0, 40, "R10", -1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule